// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch

This block drives one clock output from either of two free-running sources: an on-chip reference clock or a clock that arrives from outside the chip. A single select line chooses between them. When the line is high the reference clock is used, and when it is low the outside clock is used. Each change of source goes through a hand-over. The output first stays low, and the new source is then let through from the start of a whole high phase. Downstream logic therefore never sees a shortened pulse.

The two directions of hand-over are started in different ways. Leaving the reference clock is noticed on a falling edge of that clock. Leaving the outside clock depends only on its level: the block waits for that clock to be low. If the outside clock has simply stopped low, the return to the reference clock still completes. If the outside clock is stuck high, the return stays pending and the output keeps following the stuck level.

Top module: `clk_src_switch`

## Requirements
- R1: While `rstN` is low, `clkOut` is held low, even during the high phase of `intClk`.
- R2: After `rstN` rises with `selInt` high, `clkOut` follows `intClk`. The first pulse it passes is a full high phase of `intClk`.
- R3: After `selInt` falls from 1 to 0, `clkOut` ends up following `extClk`. The low gap across the hand-over lasts at least half an `intClk` period plus the low phase of `extClk`.
- R4: Every high pulse on `clkOut` is a full high phase of one source, and every low interval is at least half an `intClk` period long, including during hand-overs.
- R5: After `selInt` rises from 0 to 1 while `extClk` is running, `clkOut` ends up following `intClk` again.
- R6: When `extClk` has stopped at a low level, raising `selInt` still returns `clkOut` to `intClk`.
- R7: When `extClk` is stuck high, raising `selInt` never completes the return. `clkOut` stays high with no rising edge until `extClk` next goes low.
- R8: The two source enables are never active together. While the outside clock is selected, no part of `intClk` appears on `clkOut`, so `clkOut` equals `extClk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| intClk | input | 1 | On-chip reference clock |
| extClk | input | 1 | Clock from outside the chip; it may stop low or stick high |
| rstN | input | 1 | Asynchronous reset, active low |
| selInt | input | 1 | Source select: 1 chooses `intClk`, 0 chooses `extClk` |
| clkOut | output | 1 | Switched clock output |

## Verification
The properties sample the outside clock at edges of the reference clock. They therefore assume that each high phase and each low phase of `extClk` lasts longer than one `intClk` period. Under that assumption, two reference edges in a row that both see `extClk` high belong to the same high phase. The bench respects this by running `extClk` with a 13 ns half period against a 10 ns reference period. Its edges are placed half a nanosecond off the reference grid, so that no sample coincides with a transition. When the outside clock is stopped or stuck, it is changed only after it has finished a complete cycle, so the stimulus itself never contains a runt.

// File: rtl/clksw_pkg.sv
`timescale 1ns/100ps
package clksw_pkg;

  // Strobes from the control section to the gating datapath
  typedef struct packed {
    logic intEn;   // pass the reference clock
    logic extEn;   // pass the outside clock
  } gateStrobes_t;

endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/100ps
// Multi-stage level synchronizer with a selectable reset value
module clksw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RST_VAL;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/100ps
// Enable control for both clock domains
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         intClk,
  input  logic         extClk,
  input  logic         rstN,
  input  logic         selInt,
  output gateStrobes_t gate
);

  logic intEn, extEn;
  logic selIntI, extEnI;   // seen in the reference domain
  logic selIntE, intEnE;   // seen in the outside domain
  logic extClr;

  // Reference-domain view of the select line and of the outside enable
  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSelI (
    .clk(intClk), .rstN(rstN), .din(selInt), .dout(selIntI));
  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uExtI (
    .clk(intClk), .rstN(rstN), .din(extEn), .dout(extEnI));

  // Outside-domain view of the select line and of the reference enable
  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSelE (
    .clk(extClk), .rstN(rstN), .din(selInt), .dout(selIntE));
  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uIntE (
    .clk(extClk), .rstN(rstN), .din(intEn), .dout(intEnE));

  // Reference enable changes only while intClk is low
  always_ff @(negedge intClk or negedge rstN) begin
    if (!rstN) intEn <= 1'b0;
    else       intEn <= selIntI & ~extEnI;
  end

  // The return request clears the outside enable as soon as extClk is low,
  // so a stopped-low clock still releases, while a stuck-high one never does
  assign extClr = ~rstN | (selIntI & ~extClk);

  always_ff @(negedge extClk or posedge extClr) begin
    if (extClr) extEn <= 1'b0;
    else        extEn <= ~selIntE & ~intEnE;
  end

  assign gate.intEn = intEn;
  assign gate.extEn = extEn;

  AST_ONE_GATE: assert property (@(posedge intClk) disable iff (!rstN)
    !(intEn && extEn)); // R8

  AST_STUCK_HIGH_HOLDS: assert property (@(posedge intClk) disable iff (!rstN)
    (extClk && $past(extClk) && $past(extEn)) |-> extEn); // R7

endmodule

// File: rtl/clksw_datapath.sv
`timescale 1ns/100ps
// AND-OR gating of the two sources onto the output
module clksw_datapath
  import clksw_pkg::*;
(
  input  logic         intClk,
  input  logic         extClk,
  input  logic         rstN,
  input  gateStrobes_t gate,
  output logic         clkOut
);

  assign clkOut = (intClk & gate.intEn) | (extClk & gate.extEn);

  AST_INT_PASSES: assert property (@(negedge intClk) disable iff (!rstN)
    gate.intEn |-> clkOut); // R2

  AST_EXT_PASSES: assert property (@(negedge extClk) disable iff (!rstN)
    gate.extEn |-> clkOut); // R3

endmodule

// File: rtl/clk_src_switch.sv
`timescale 1ns/100ps
// Glitch-free switch between a reference clock and an outside clock
module clk_src_switch
  import clksw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic intClk,
  input  logic extClk,
  input  logic rstN,
  input  logic selInt,
  output logic clkOut
);

  gateStrobes_t gate;

  clksw_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .intClk(intClk), .extClk(extClk), .rstN(rstN), .selInt(selInt), .gate(gate));

  clksw_datapath uPath (
    .intClk(intClk), .extClk(extClk), .rstN(rstN), .gate(gate), .clkOut(clkOut));

endmodule

// File: tb/sim_clk_src_switch.sv
`timescale 1ns/100ps
module sim_clk_src_switch;

  logic intClk = 1'b0;
  logic extClk = 1'b0;
  logic rstN   = 1'b0;
  logic selInt = 1'b1;
  logic clkOut;

  logic extRun  = 1'b1;
  logic extHold = 1'b0;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  // pulse monitor
  bit  monOn   = 1'b0;
  realtime tRise = 0, tFall = 0;
  real maxLow  = 0.0;
  real minLow  = 1.0e9;
  real firstHigh = -1.0;
  int  runtCnt = 0;
  int  riseCnt = 0;

  clk_src_switch u0 (
    .intClk(intClk), .extClk(extClk), .rstN(rstN), .selInt(selInt), .clkOut(clkOut));

  // 100 MHz reference clock
  always #5 intClk = ~intClk;

  // outside clock: 26 ns period, offset off the reference grid; can stop or stick
  initial begin
    #0.5;
    forever begin
      if (extRun) begin
        extClk = 1'b1; #13;
        extClk = 1'b0; #13;
      end else begin
        extClk = extHold; #1;
      end
    end
  end

  always @(posedge clkOut) begin
    riseCnt++;
    if (rstN && tFall > 0 && monOn) begin
      if ((($realtime - tFall)) > maxLow) maxLow = $realtime - tFall;
      if ((($realtime - tFall)) < minLow) minLow = $realtime - tFall;
    end
    tRise = $realtime;
  end

  always @(negedge clkOut) begin
    real hw;
    hw = $realtime - tRise;
    if (rstN && firstHigh < 0.0) firstHigh = hw;
    if (monOn && !((hw > 4.5 && hw < 5.5) || (hw > 12.5 && hw < 13.5))) runtCnt++;
    tFall = $realtime;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $realtime);
    end
  endtask

  task automatic followsInt(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge intClk); #2;
      chk(clkOut == 1'b1, req, clkOut, 1);
      @(negedge intClk); #2;
      chk(clkOut == 1'b0, req, clkOut, 0);
    end
  endtask

  task automatic followsExt(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge intClk); #2;
      chk(clkOut == extClk, req, clkOut, extClk);
    end
  endtask

  task automatic testReset();
    for (int i = 0; i < 5; i++) begin
      @(posedge intClk); #2;
      chk(clkOut == 1'b0, "R1", clkOut, 0);
    end
  endtask

  task automatic testIntAfterReset();
    @(negedge intClk); #2;
    rstN = 1'b1;
    repeat (4) @(posedge intClk);
    monOn = 1'b1;
    #1;
    chk(firstHigh > 4.5 && firstHigh < 5.5, "R2 first pulse width", int'(firstHigh), 5);
    followsInt(10, "R2");
  endtask

  task automatic testToExt(input string req);
    maxLow = 0.0;
    @(negedge intClk); #3;
    selInt = 1'b0;
    repeat (30) @(posedge intClk);
    chk(maxLow >= 18.0, {req, " hand-over gap"}, int'(maxLow), 18);
    followsExt(20, req);
    followsExt(20, "R8");
  endtask

  task automatic testToInt();
    @(negedge intClk); #3;
    selInt = 1'b1;
    repeat (20) @(posedge intClk);
    followsInt(10, "R5");
  endtask

  task automatic testStoppedLow();
    testToExt("R3");
    extHold = 1'b0;
    extRun  = 1'b0;
    repeat (5) @(posedge intClk);
    @(negedge intClk); #3;
    selInt = 1'b1;
    repeat (20) @(posedge intClk);
    followsInt(10, "R6");
    extRun = 1'b1;
    repeat (5) @(posedge intClk);
  endtask

  task automatic testStuckHigh();
    int snap;
    testToExt("R3");
    monOn   = 1'b0;
    extHold = 1'b1;
    extRun  = 1'b0;
    repeat (5) @(posedge intClk);
    @(negedge intClk); #3;
    selInt = 1'b1;
    repeat (10) @(posedge intClk);
    snap = riseCnt;
    for (int i = 0; i < 20; i++) begin
      @(negedge intClk); #2;
      chk(clkOut == 1'b1, "R7 output held", clkOut, 1);
    end
    chk(riseCnt == snap, "R7 no rising edge", riseCnt - snap, 0);
    extRun = 1'b1;
    repeat (20) @(posedge intClk);
    monOn = 1'b1;
    followsInt(10, "R5 after release");
  endtask

  initial begin
    testReset();
    testIntAfterReset();
    testToExt("R3");
    testToInt();
    testStoppedLow();
    testStuckHigh();
    testToExt("R3");
    testToInt();
    chk(runtCnt == 0, "R4 runt pulses", runtCnt, 0);
    chk(minLow >= 4.5, "R4 shortest low", int'(minLow), 5);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule